// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is the command front end of a byte-wide parallel NOR flash. It watches single-cycle bus writes, each carrying an address and a data byte, and recognises command sequences. Every sequence opens with a two-write unlock at fixed key addresses. When a sequence is recognised, the block issues a one-cycle request to the operation engine. The requests are a byte program (with target address and data), a whole-array erase, a single-sector erase (with a sector index), or a boot-sector lock. A wrong cycle anywhere in a sequence drops the interpreter back to plain array reading.

The block also reports a mode: array read, identification, or busy. While the engine reports busy, bus writes are discarded. In identification mode, reads return the manufacturer code, the device code and the boot-lock status. Once the boot sector is locked, the block silently drops every request that would alter that sector, including a whole-array erase.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the mode is array read (code 00), no request is raised, id_valid is 0 and the boot sector is unlocked.
- R2: The unlock pair is AAh written to key address 5555h, then 55h written to 2AAAh. Only address bits 15:0 are compared, so bits 17:16 are ignored.
- R3: Unlock, then A0h to 5555h, then any write (including data F0h) raises prog_req for one cycle, in the cycle after that write. prog_addr and prog_data carry that write's address and data.
- R4: Unlock, 80h to 5555h, unlock, 10h to 5555h raises erase_req with erase_chip=1, in the cycle after the last write.
- R5: The same six-write sequence ending with 30h at any address raises erase_req with erase_chip=0 and erase_sect set as follows: 0 for 00000h-1FFFFh, 1 for 20000h-37FFFh, 2 for 38000h-39FFFh, 3 for 3A000h-3BFFFh, 4 (boot) for 3C000h-3FFFFh.
- R6: The erase-style sequence ending with 40h at 5555h raises lock_req for one cycle and sets the boot lock. The lock stays set until reset.
- R7: While the boot lock is set, a program aimed at the boot sector, a sector erase of sector 4 and a whole-array erase raise no request. Other sectors are still served.
- R8: Unlock then 90h to 5555h enters identification mode (code 01), which persists across any number of reads. A read with rd_en returns id_valid=1 one cycle later, with data chosen by rd_addr[7:0]: 00h gives 8Ch; 04h, 08h and 0Ch give 7Fh; 01h gives the device code (default B2h); 02h gives the lock status in bit 0; any other offset gives 00h. In array-read mode id_valid stays 0.
- R9: F0h written to any address, at any step except the program data step, returns the block to array read. This covers unlock followed by F0h at 5555h.
- R10: A write that does not match the expected step returns the block to array read with an idle sequence. A later partial sequence therefore does nothing.
- R11: While eng_busy is 1 the mode is busy (code 10), and every bus write is ignored without changing the sequence state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 18 | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 18 | Bus read address |
| eng_busy | input | 1 | Operation engine is running |
| prog_req | output | 1 | Byte program request pulse |
| prog_addr | output | 18 | Program target address |
| prog_data | output | 8 | Program data byte |
| erase_req | output | 1 | Erase request pulse |
| erase_chip | output | 1 | 1 = whole array, 0 = one sector |
| erase_sect | output | 3 | Sector index for a sector erase |
| lock_req | output | 1 | Boot lock request pulse |
| mode | output | 2 | 00 array read, 01 identification, 10 busy |
| id_valid | output | 1 | Identification byte valid |
| id_rdata | output | 8 | Identification byte |

## Verification
A wrong sequence state shows up at the ports no later than the write that completes a sequence. That write either raises a request that should not exist or misses one that should, so each directed and random sequence is judged by counting request pulses, not by sampling a single cycle. A wrong identification flag shows up on the very next read as a missing or extra id_valid. A lost or stray boot lock shows up on the next lock-status read, and on the next program or erase aimed at the boot sector.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int ADDR_W    = 18;
  localparam int DATA_W    = 8;
  localparam int KEY_AW    = 16;
  localparam int N_SECT    = 5;
  localparam int SECT_W    = $clog2(N_SECT);
  localparam int BOOT_SECT = N_SECT - 1;
  localparam int ID_OFS_W  = 8;

  localparam logic [KEY_AW-1:0] KEY_ADDR_A = 16'h5555;
  localparam logic [KEY_AW-1:0] KEY_ADDR_B = 16'h2AAA;

  localparam logic [DATA_W-1:0] OP_UNL1  = 8'hAA;
  localparam logic [DATA_W-1:0] OP_UNL2  = 8'h55;
  localparam logic [DATA_W-1:0] OP_PROG  = 8'hA0;
  localparam logic [DATA_W-1:0] OP_ESET  = 8'h80;
  localparam logic [DATA_W-1:0] OP_IDENT = 8'h90;
  localparam logic [DATA_W-1:0] OP_RESET = 8'hF0;
  localparam logic [DATA_W-1:0] OP_CHIP  = 8'h10;
  localparam logic [DATA_W-1:0] OP_SECT  = 8'h30;
  localparam logic [DATA_W-1:0] OP_LOCK  = 8'h40;

  typedef enum logic [1:0] {
    MODE_READ = 2'b00,
    MODE_ID   = 2'b01,
    MODE_BUSY = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PROG, SQ_E1, SQ_E2, SQ_E3
  } seq_e;

  typedef enum logic [3:0] {
    K_OTHER, K_UNL1, K_UNL2, K_RESET, K_PROG, K_ESET,
    K_IDENT, K_CHIP, K_SECT, K_LOCK
  } kind_e;

  // Sector index from a full array address; the boundaries follow the fixed map.
  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    logic [SECT_W-1:0] r;
    if (!a[17])                r = SECT_W'(0);
    else if (a[16:15] != 2'b11) r = SECT_W'(1);
    else if (a[14])            r = SECT_W'(4);
    else if (a[13])            r = SECT_W'(3);
    else                       r = SECT_W'(2);
    return r;
  endfunction

  // Identification byte selected by a read offset.
  function automatic logic [DATA_W-1:0] id_byte(
    input logic [ID_OFS_W-1:0] ofs, input logic lock,
    input logic [DATA_W-1:0] mfr, input logic [DATA_W-1:0] cont,
    input logic [DATA_W-1:0] dev);
    logic [DATA_W-1:0] r;
    case (ofs)
      8'h00:               r = mfr;
      8'h04, 8'h08, 8'h0C: r = cont;
      8'h01:               r = dev;
      8'h02:               r = {{(DATA_W-1){1'b0}}, lock};
      default:             r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/nor_bus_match.sv
module nor_bus_match
  import nor_cmd_pkg::*;
(
  input  logic [KEY_AW-1:0] key_addr,
  input  logic [DATA_W-1:0] data,
  output kind_e             kind
);
  logic at_a, at_b;
  assign at_a = (key_addr == KEY_ADDR_A);
  assign at_b = (key_addr == KEY_ADDR_B);

  always_comb begin
    kind = K_OTHER;
    if (at_a && data == OP_UNL1)      kind = K_UNL1;
    else if (at_b && data == OP_UNL2) kind = K_UNL2;
    else if (data == OP_RESET)        kind = K_RESET;
    else if (data == OP_SECT)         kind = K_SECT;
    else if (at_a) begin
      case (data)
        OP_PROG:  kind = K_PROG;
        OP_ESET:  kind = K_ESET;
        OP_IDENT: kind = K_IDENT;
        OP_CHIP:  kind = K_CHIP;
        OP_LOCK:  kind = K_LOCK;
        default:  kind = K_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  kind_e             kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [SECT_W-1:0] erase_sect,
  output logic              lock_req,
  output logic              id_mode,
  output logic              boot_lock
);
  seq_e seq_q, seq_d;
  logic id_d, lock_d;
  logic go_prog, go_sect, go_chip, go_lock;
  logic [SECT_W-1:0] tgt_sect;
  logic tgt_boot;

  assign tgt_sect = sector_of(wr_addr);
  assign tgt_boot = (tgt_sect == SECT_W'(BOOT_SECT));

  always_comb begin
    seq_d   = seq_q;
    id_d    = id_mode;
    lock_d  = boot_lock;
    go_prog = 1'b0;
    go_sect = 1'b0;
    go_chip = 1'b0;
    go_lock = 1'b0;
    if (wr_fire) begin
      seq_d = SQ_IDLE;
      unique case (seq_q)
        SQ_IDLE: begin
          if (kind == K_UNL1) seq_d = SQ_U1;
          else                id_d  = 1'b0;
        end
        SQ_U1: begin
          if (kind == K_UNL2) seq_d = SQ_U2;
          else                id_d  = 1'b0;
        end
        SQ_U2: begin
          case (kind)
            K_PROG:  seq_d = SQ_PROG;
            K_ESET:  seq_d = SQ_E1;
            K_IDENT: id_d  = 1'b1;
            default: id_d  = 1'b0;
          endcase
        end
        SQ_PROG: begin
          id_d    = 1'b0;
          go_prog = !(boot_lock && tgt_boot);
        end
        SQ_E1: begin
          if (kind == K_UNL1) seq_d = SQ_E2;
          else                id_d  = 1'b0;
        end
        SQ_E2: begin
          if (kind == K_UNL2) seq_d = SQ_E3;
          else                id_d  = 1'b0;
        end
        SQ_E3: begin
          id_d = 1'b0;
          case (kind)
            K_CHIP: go_chip = !boot_lock;
            K_SECT: go_sect = !(boot_lock && tgt_boot);
            K_LOCK: begin
              lock_d  = 1'b1;
              go_lock = 1'b1;
            end
            default: ;
          endcase
        end
        default: id_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= SQ_IDLE;
      id_mode    <= 1'b0;
      boot_lock  <= 1'b0;
      prog_req   <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
      erase_req  <= 1'b0;
      erase_chip <= 1'b0;
      erase_sect <= '0;
      lock_req   <= 1'b0;
    end else begin
      seq_q     <= seq_d;
      id_mode   <= id_d;
      boot_lock <= lock_d;
      prog_req  <= go_prog;
      erase_req <= go_sect | go_chip;
      lock_req  <= go_lock;
      if (go_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (go_chip) begin
        erase_chip <= 1'b1;
        erase_sect <= '0;
      end else if (go_sect) begin
        erase_chip <= 1'b0;
        erase_sect <= tgt_sect;
      end
    end
  end
endmodule

// File: rtl/nor_id_port.sv
module nor_id_port
  import nor_cmd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MFR_CODE  = 8'h8C,
  parameter logic [DATA_W-1:0] CONT_CODE = 8'h7F,
  parameter logic [DATA_W-1:0] DEV_CODE  = 8'hB2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic                active,
  input  logic [ID_OFS_W-1:0] rd_ofs,
  input  logic                lock,
  output logic                id_valid,
  output logic [DATA_W-1:0]   id_rdata
);
  logic take;
  assign take = rd_en & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      id_rdata <= '0;
    end else begin
      id_valid <= take;
      id_rdata <= take ? id_byte(rd_ofs, lock, MFR_CODE, CONT_CODE, DEV_CODE) : '0;
    end
  end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MFR_CODE  = 8'h8C,
  parameter logic [DATA_W-1:0] CONT_CODE = 8'h7F,
  parameter logic [DATA_W-1:0] DEV_CODE  = 8'hB2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              eng_busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic              erase_chip,
  output logic [SECT_W-1:0] erase_sect,
  output logic              lock_req,
  output logic [1:0]        mode,
  output logic              id_valid,
  output logic [DATA_W-1:0] id_rdata
);
  // Named internal events, visible to the bound checker.
  logic  wr_fire;
  logic  id_mode;
  logic  boot_lock;
  logic  id_active;
  kind_e kind;
  mode_e mode_w;
  logic  unused_rd_hi;

  assign wr_fire      = wr_en & ~eng_busy;
  assign id_active    = id_mode & ~eng_busy;
  assign unused_rd_hi = ^rd_addr[ADDR_W-1:ID_OFS_W];

  nor_bus_match u_match (
    .key_addr (wr_addr[KEY_AW-1:0]),
    .data     (wr_data),
    .kind     (kind)
  );

  nor_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .kind       (kind),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prog_req   (prog_req),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .erase_req  (erase_req),
    .erase_chip (erase_chip),
    .erase_sect (erase_sect),
    .lock_req   (lock_req),
    .id_mode    (id_mode),
    .boot_lock  (boot_lock)
  );

  nor_id_port #(
    .MFR_CODE  (MFR_CODE),
    .CONT_CODE (CONT_CODE),
    .DEV_CODE  (DEV_CODE)
  ) u_id (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .active   (id_active),
    .rd_ofs   (rd_addr[ID_OFS_W-1:0]),
    .lock     (boot_lock),
    .id_valid (id_valid),
    .id_rdata (id_rdata)
  );

  always_comb begin
    if (eng_busy)     mode_w = MODE_BUSY;
    else if (id_mode) mode_w = MODE_ID;
    else              mode_w = MODE_READ;
  end
  assign mode = mode_w;
endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk
  import nor_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              eng_busy,
  input logic              prog_req,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [DATA_W-1:0] prog_data,
  input logic              erase_req,
  input logic              erase_chip,
  input logic [SECT_W-1:0] erase_sect,
  input logic              lock_req,
  input logic [1:0]        mode,
  input logic              id_valid,
  input logic              boot_lock
);
  assert_prog_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> ($past(wr_en) && !$past(eng_busy) &&
                  prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

  assert_single_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req, lock_req}));

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    boot_lock |=> boot_lock);

  assert_lock_req_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |-> boot_lock);

  assert_locked_chip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && erase_chip) |-> !$past(boot_lock));

  assert_locked_sector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_chip && erase_sect == SECT_W'(BOOT_SECT)) |-> !$past(boot_lock));

  assert_id_only_in_id_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> ($past(rd_en) && $past(mode) == MODE_ID));

  assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && eng_busy) |=> !(prog_req || erase_req || lock_req));
endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .eng_busy   (eng_busy),
  .prog_req   (prog_req),
  .prog_addr  (prog_addr),
  .prog_data  (prog_data),
  .erase_req  (erase_req),
  .erase_chip (erase_chip),
  .erase_sect (erase_sect),
  .lock_req   (lock_req),
  .mode       (mode),
  .id_valid   (id_valid),
  .boot_lock  (boot_lock)
);

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [17:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [17:0] rd_addr = '0;
  logic        eng_busy = 1'b0;
  logic        prog_req, erase_req, erase_chip, lock_req, id_valid;
  logic [17:0] prog_addr;
  logic [7:0]  prog_data, id_rdata;
  logic [2:0]  erase_sect;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  int n_prog = 0, n_erase = 0, n_lock = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nor_cmd_decoder i_nor_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .eng_busy(eng_busy),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .erase_chip(erase_chip), .erase_sect(erase_sect),
    .lock_req(lock_req), .mode(mode), .id_valid(id_valid), .id_rdata(id_rdata)
  );

  always @(negedge clk) begin
    if (prog_req)  n_prog++;
    if (erase_req) n_erase++;
    if (lock_req)  n_lock++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_sector(input logic [17:0] a);
    if (a < 18'h20000) return 3'd0;
    if (a < 18'h38000) return 3'd1;
    if (a < 18'h3A000) return 3'd2;
    if (a < 18'h3C000) return 3'd3;
    return 3'd4;
  endfunction

  function automatic logic [7:0] exp_id(input logic [7:0] ofs, input bit lk);
    if (ofs == 8'h00) return 8'h8C;
    if (ofs == 8'h04 || ofs == 8'h08 || ofs == 8'h0C) return 8'h7F;
    if (ofs == 8'h01) return 8'hB2;
    if (ofs == 8'h02) return {7'd0, lk};
    return 8'h00;
  endfunction

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [17:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic unlock();
    wr({2'($urandom), 16'h5555}, 8'hAA);
    wr({2'($urandom), 16'h2AAA}, 8'h55);
  endtask

  task automatic key(input logic [7:0] d);
    wr({2'($urandom), 16'h5555}, d);
  endtask

  task automatic do_prog(input logic [17:0] a, input logic [7:0] d);
    unlock(); key(8'hA0); wr(a, d);
  endtask

  task automatic do_erase(input logic [17:0] a, input logic [7:0] d);
    unlock(); key(8'h80); unlock(); wr(a, d);
  endtask

  task automatic do_ident();
    unlock(); key(8'h90);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0, e0, l0;
    logic [17:0] a;
    logic [7:0]  d;
    logic [17:0] sect_pts [10];
    void'($urandom(32'd20240917));
    sect_pts = '{18'h00000, 18'h1FFFF, 18'h20000, 18'h37FFF, 18'h38000,
                 18'h39FFF, 18'h3A000, 18'h3BFFF, 18'h3C000, 18'h3FFFF};

    apply_reset();
    // R1 reset state
    check("R1 mode after reset", mode, 2'b00);
    check("R1 no request after reset", {prog_req, erase_req, lock_req}, 3'b000);
    check("R1 id_valid after reset", id_valid, 1'b0);

    // R2 R3 program with upper address bits set on the key cycles
    p0 = n_prog;
    wr(18'h35555, 8'hAA); wr(18'h12AAA, 8'h55); wr(18'h25555, 8'hA0);
    wr(18'h31234, 8'h5A);
    check("R2 unlock ignores bits 17:16", n_prog - p0, 1);
    check("R3 prog_addr", prog_addr, 18'h31234);
    check("R3 prog_data", prog_data, 8'h5A);
    check("R3 mode back to read", mode, 2'b00);
    p0 = n_prog;
    do_prog(18'h00010, 8'hF0);
    check("R3 F0 as program data", n_prog - p0, 1);
    check("R3 prog_data F0", prog_data, 8'hF0);

    // R4 whole-array erase
    e0 = n_erase;
    do_erase(18'h05555, 8'h10);
    check("R4 chip erase pulse", n_erase - e0, 1);
    check("R4 erase_chip", erase_chip, 1'b1);

    // R5 sector erase at every boundary
    foreach (sect_pts[i]) begin
      e0 = n_erase;
      do_erase(sect_pts[i], 8'h30);
      check("R5 sector erase pulse", n_erase - e0, 1);
      check("R5 sector index", {erase_chip, erase_sect}, {1'b0, exp_sector(sect_pts[i])});
    end

    // R8 identification mode and reads
    do_ident();
    check("R8 mode id", mode, 2'b01);
    foreach (sect_pts[i]) begin
      d = 8'($urandom_range(0, 15));
      a = {10'($urandom), d};
      rd(a);
      check("R8 id_valid", id_valid, 1'b1);
      check("R8 id byte", id_rdata, exp_id(d, 1'b0));
    end
    rd(18'h2AB02);
    check("R8 lock status unlocked", id_rdata, 8'h00);
    check("R8 mode persists", mode, 2'b01);

    // R9 F0 at any address leaves id mode
    wr(18'h1F3C7, 8'hF0);
    check("R9 F0 anywhere to read", mode, 2'b00);
    rd(18'h00000);
    check("R9 no id in read mode", id_valid, 1'b0);
    do_ident();
    unlock(); key(8'hF0);
    check("R9 unlock F0 to read", mode, 2'b00);

    // R10 wrong cycle resets the sequence
    p0 = n_prog; e0 = n_erase;
    wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55);
    wr(18'h02AAA, 8'h55); key(8'hA0); wr(18'h00100, 8'h11);
    check("R10 bad unlock address drops program", n_prog - p0, 0);
    unlock(); key(8'h80); wr(18'h05556, 8'hAA); wr(18'h02AAA, 8'h55); key(8'h10);
    check("R10 bad erase step drops erase", n_erase - e0, 0);
    do_ident(); wr(18'h00000, 8'h77);
    check("R10 stray write leaves id mode", mode, 2'b00);

    // R11 busy: writes ignored, sequence state kept
    p0 = n_prog;
    wr(18'h05555, 8'hAA);
    @(negedge clk); eng_busy = 1'b1; #1;
    check("R11 mode busy", mode, 2'b10);
    wr(18'h02AAA, 8'h55); wr(18'h05555, 8'hA0); wr(18'h00200, 8'h22);
    do_prog(18'h00300, 8'h33);
    check("R11 no program while busy", n_prog - p0, 0);
    @(negedge clk); eng_busy = 1'b0; #1;
    check("R11 mode read after busy", mode, 2'b00);
    wr(18'h02AAA, 8'h55); key(8'hA0); wr(18'h00400, 8'h44);
    check("R11 state held across busy", n_prog - p0, 1);
    check("R11 addr after busy", prog_addr, 18'h00400);

    // R6 boot lock
    l0 = n_lock;
    do_erase(18'h05555, 8'h40);
    check("R6 lock pulse", n_lock - l0, 1);
    do_ident(); rd(18'h00002);
    check("R6 lock status set", id_rdata, 8'h01);
    wr(18'h00000, 8'hF0);

    // R7 locked boot sector
    p0 = n_prog; e0 = n_erase;
    do_prog(18'h3C100, 8'h01);
    check("R7 boot program dropped", n_prog - p0, 0);
    do_erase(18'h3D000, 8'h30);
    do_erase(18'h05555, 8'h10);
    check("R7 boot and chip erase dropped", n_erase - e0, 0);
    do_prog(18'h3B000, 8'h02);
    check("R7 other sector program", n_prog - p0, 1);
    do_erase(18'h3A000, 8'h30);
    check("R7 other sector erase", {n_erase - e0, erase_sect}, {32'd1, 3'd3});

    // Random programs and sector erases with the lock set
    for (int k = 0; k < 40; k++) begin
      a = 18'($urandom); d = 8'($urandom);
      p0 = n_prog;
      do_prog(a, d);
      if (a < 18'h3C000) begin
        check("R3 random program pulse", n_prog - p0, 1);
        check("R3 random program word", {prog_addr, prog_data}, {a, d});
      end else
        check("R7 random boot program dropped", n_prog - p0, 0);
      a = 18'($urandom); e0 = n_erase;
      do_erase(a, 8'h30);
      if (exp_sector(a) != 3'd4)
        check("R5 random sector", {n_erase - e0, erase_sect}, {32'd1, exp_sector(a)});
      else
        check("R7 random boot erase dropped", n_erase - e0, 0);
    end

    // R1 lock clears only on reset
    apply_reset();
    do_ident(); rd(18'h00002);
    check("R1 lock cleared by reset", id_rdata, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule